// File: doc/BRIEF.md
# Headphone supply mode sequencer

This block orders the supply and amplifier-mode settings around an audio output path as that path is switched on or off. A request names one output path (earpiece, left headphone, right headphone or line-out), says whether the event is the pre-DAC enable or the post-PA disable, and names the amplifier mode. The sequencer checks the request against the set of paths that are already active and against the modes that the path accepts. If the request is legal, it steps through an ordered list of control writes: class-H block clock, per-path class-H enable, filter coefficient, regulator mode, rail power levels, rail bias load, headphone power level, peak-current step and gain-path select.

Switching a rail on or off is handed to an external rail controller through a request/acknowledge handshake. A microsecond tick input times the settling wait after the bias load, so the wait does not depend on the clock frequency. The class-H clock is shared by the earpiece and both headphone paths. It is reference-counted, so it stays on while any class-H user remains.

Top module: `hp_supply_seq`

## Requirements
- R1: After reset every control output is 0, `busy` and `req_err` are 0 and `cur_state` is 0 (no path active).
- R2: `req_path` is one-hot: bit 0 earpiece, bit 1 left headphone, bit 2 right headphone, bit 3 line-out. `cur_state` uses the same bits to hold the set of active paths. A request whose resulting set (enable: set OR path; disable: set AND NOT path) equals `cur_state` is ignored: no busy, no error, no output change. This covers a zero path.
- R3: A request that is not ignored and whose path has more than one bit set pulses `req_err` for one cycle after the request and changes nothing else.
- R4: Mode codes are 0 normal class-H, 1 HiFi, 2 low power, 3 class-AB, 4 low HiFi, 5 none. The earpiece accepts only 0, line-out accepts only 3, and a headphone accepts 1 to 5. Any other combination pulses `req_err` and changes nothing else.
- R5: Headphone enable runs in this order: class-H step, regulator mode, negative level, negative rail on, bias load, wait, positive level, positive rail on, headphone power and peak current, gain path. The class-H step sets the clock user, the path enable and `k1_coef` = 0x0C0; in class-AB it is a one-cycle step that writes nothing.
- R6: Earpiece enable runs class-H step, positive level, negative level, negative rail on, bias load, wait, positive rail on. Line-out enable runs regulator mode, positive level, negative level, negative rail on, bias load, wait, positive rail on.
- R7: Headphone disable runs headphone power to normal, class-H step (off, skipped in class-AB), positive rail off, negative rail off, negative level, positive level, regulator mode. Earpiece disable omits the power and regulator steps. Line-out disable omits the power and class-H steps. Levels and regulator revert to 0, and the gain path is left unchanged.
- R8: `clsh_clk_en` rises only when the class-H user count goes from 0 to 1 and falls only when it returns to 0. `path_clsh_en` (bit 0 earpiece, bit 1 left, bit 2 right) follows each path's class-H step.
- R9: `reg_ab` is 1 only in class-AB; `vpos_hifi`/`vneg_hifi` are 1 only in HiFi. `hph_pwr` is 2 in HiFi, 1 in low power, else 0. `gain_sel` is 2 (HQ) in HiFi, 1 (LP) in low power, else 0 (bypass). `ipeak_30ma` is 1 only in low power.
- R10: `bias_load` pulses for one cycle. The next step begins only after exactly BIAS_US further `us_tick` pulses.
- R11: Each rail step holds `rail_req` with `rail_pos` (1 = positive rail) and `rail_on` (1 = switch on) stable until `rail_ack`. The step then completes in that cycle.
- R12: `busy` is high from the cycle after an accepted request until the last step completes. Requests while busy are dropped. `cur_state` and `cur_mode` update only at completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| req_valid | input | 1 | Request strobe |
| req_enable | input | 1 | 1 = pre-DAC enable, 0 = post-PA disable |
| req_path | input | 4 | One-hot output path |
| req_mode | input | 3 | Amplifier mode code |
| rail_ack | input | 1 | Rail controller acknowledge |
| busy | output | 1 | Sequence running |
| req_err | output | 1 | One-cycle rejected-request pulse |
| cur_state | output | 4 | Set of active paths |
| cur_mode | output | 3 | Mode of the last completed sequence |
| clsh_clk_en | output | 1 | Class-H block clock enable |
| path_clsh_en | output | 3 | Per-path class-H enable |
| k1_coef | output | 12 | Class-H filter coefficient |
| reg_ab | output | 1 | Regulator in class-AB mode |
| vneg_hifi | output | 1 | Negative rail HiFi power level |
| vpos_hifi | output | 1 | Positive rail HiFi power level |
| bias_load | output | 1 | Rail bias current load pulse |
| hph_pwr | output | 2 | Headphone power level |
| ipeak_30ma | output | 1 | Peak-current step 30 mA (else 50 mA) |
| gain_sel | output | 2 | Headphone gain-path select |
| rail_req | output | 1 | Rail switch request |
| rail_pos | output | 1 | Request targets the positive rail |
| rail_on | output | 1 | Request switches the rail on |

## Verification
A wrong step pointer or a wrong sequence list shows at the ports within one cycle. Some control output changes in the wrong cycle, or a rail request appears early or late, and a model that tracks the sequence cycle by cycle catches it at once. A wrong class-H user count stays hidden until a later path shuts down. The clock then falls too early or stays on, so the tests close several overlapping paths in turn. A miscounted settling wait moves the first rail request after the bias pulse by whole ticks, which the tick count between the two events exposes.

// File: rtl/hp_supply_seq.sv
module hp_supply_seq #(
  parameter int          BIAS_US = 100,
  parameter int          USER_W  = 3,
  parameter logic [11:0] K1_LOAD = 12'h0C0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        us_tick,
  input  logic        req_valid,
  input  logic        req_enable,
  input  logic [3:0]  req_path,
  input  logic [2:0]  req_mode,
  input  logic        rail_ack,
  output logic        busy,
  output logic        req_err,
  output logic [3:0]  cur_state,
  output logic [2:0]  cur_mode,
  output logic        clsh_clk_en,
  output logic [2:0]  path_clsh_en,
  output logic [11:0] k1_coef,
  output logic        reg_ab,
  output logic        vneg_hifi,
  output logic        vpos_hifi,
  output logic        bias_load,
  output logic [1:0]  hph_pwr,
  output logic        ipeak_30ma,
  output logic [1:0]  gain_sel,
  output logic        rail_req,
  output logic        rail_pos,
  output logic        rail_on
);

  localparam int WAIT_W = $clog2(BIAS_US + 1);
  localparam logic [2:0] M_NORM = 3'd0, M_HIFI = 3'd1, M_LP = 3'd2, M_AB = 3'd3, M_LAST = 3'd5;
  localparam logic [1:0] K_EAR = 2'd0, K_HP = 2'd1, K_LO = 2'd2;
  localparam logic [1:0] L_NORM = 2'd0, L_LP = 2'd1, L_HQ = 2'd2;

  typedef enum logic [3:0] {
    S_END, S_CLSH, S_REG, S_NLVL, S_NRAIL, S_BIAS, S_WAIT, S_PLVL, S_PRAIL, S_HPH, S_GAIN
  } step_t;

  function automatic step_t seq_at(input logic [1:0] kind, input logic en, input logic [3:0] idx);
    step_t s;
    s = S_END;
    case ({kind, en})
      {K_EAR, 1'b1}:
        case (idx)
          4'd0: s = S_CLSH;  4'd1: s = S_PLVL; 4'd2: s = S_NLVL; 4'd3: s = S_NRAIL;
          4'd4: s = S_BIAS;  4'd5: s = S_WAIT; 4'd6: s = S_PRAIL;
          default: s = S_END;
        endcase
      {K_HP, 1'b1}:
        case (idx)
          4'd0: s = S_CLSH;  4'd1: s = S_REG;   4'd2: s = S_NLVL; 4'd3: s = S_NRAIL;
          4'd4: s = S_BIAS;  4'd5: s = S_WAIT;  4'd6: s = S_PLVL; 4'd7: s = S_PRAIL;
          4'd8: s = S_HPH;   4'd9: s = S_GAIN;
          default: s = S_END;
        endcase
      {K_LO, 1'b1}:
        case (idx)
          4'd0: s = S_REG;   4'd1: s = S_PLVL; 4'd2: s = S_NLVL; 4'd3: s = S_NRAIL;
          4'd4: s = S_BIAS;  4'd5: s = S_WAIT; 4'd6: s = S_PRAIL;
          default: s = S_END;
        endcase
      {K_EAR, 1'b0}:
        case (idx)
          4'd0: s = S_CLSH;  4'd1: s = S_PRAIL; 4'd2: s = S_NRAIL; 4'd3: s = S_NLVL;
          4'd4: s = S_PLVL;
          default: s = S_END;
        endcase
      {K_HP, 1'b0}:
        case (idx)
          4'd0: s = S_HPH;   4'd1: s = S_CLSH; 4'd2: s = S_PRAIL; 4'd3: s = S_NRAIL;
          4'd4: s = S_NLVL;  4'd5: s = S_PLVL; 4'd6: s = S_REG;
          default: s = S_END;
        endcase
      {K_LO, 1'b0}:
        case (idx)
          4'd0: s = S_PRAIL; 4'd1: s = S_NRAIL; 4'd2: s = S_NLVL; 4'd3: s = S_PLVL;
          4'd4: s = S_REG;
          default: s = S_END;
        endcase
      default: s = S_END;
    endcase
    return s;
  endfunction

  logic              run, en_q;
  logic [1:0]        kind_q, psel;
  logic [2:0]        mode_q;
  logic [3:0]        path_q, idx, new_set;
  logic [WAIT_W-1:0] wcnt;
  logic [USER_W-1:0] users;
  step_t             step, step_nx;
  logic              is_rail, adv, path_ok, mode_ok, take, uses_clsh;

  assign step      = run ? seq_at(kind_q, en_q, idx) : S_END;
  assign step_nx   = seq_at(kind_q, en_q, idx + 4'd1);
  assign is_rail   = (step == S_NRAIL) || (step == S_PRAIL);
  assign adv       = run && (is_rail ? rail_ack :
                             (step == S_WAIT) ? (us_tick && wcnt == WAIT_W'(BIAS_US - 1)) : 1'b1);
  assign psel      = path_q[0] ? 2'd0 : path_q[1] ? 2'd1 : 2'd2;
  assign uses_clsh = (mode_q != M_AB);

  assign busy     = run;
  assign rail_req = is_rail;
  assign rail_pos = (step == S_PRAIL);
  assign rail_on  = is_rail && en_q;

  assign new_set = req_enable ? (cur_state | req_path) : (cur_state & ~req_path);
  assign path_ok = (req_path & (req_path - 4'd1)) == 4'd0;
  assign take    = req_valid && !run && (new_set != cur_state);

  always_comb begin
    if (req_path[0])                   mode_ok = (req_mode == M_NORM);
    else if (req_path[3])              mode_ok = (req_mode == M_AB);
    else if (req_path[1] | req_path[2]) mode_ok = (req_mode != M_NORM) && (req_mode <= M_LAST);
    else                               mode_ok = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; en_q <= 1'b0; kind_q <= K_EAR; mode_q <= M_NORM; path_q <= '0; idx <= '0;
      wcnt <= '0; users <= '0; req_err <= 1'b0; cur_state <= '0; cur_mode <= M_NORM;
      clsh_clk_en <= 1'b0; path_clsh_en <= '0; k1_coef <= '0; reg_ab <= 1'b0;
      vneg_hifi <= 1'b0; vpos_hifi <= 1'b0; bias_load <= 1'b0; hph_pwr <= L_NORM;
      ipeak_30ma <= 1'b0; gain_sel <= L_NORM;
    end else begin
      req_err   <= 1'b0;
      bias_load <= 1'b0;
      if (take) begin
        if (!path_ok || !mode_ok) req_err <= 1'b1;
        else begin
          run    <= 1'b1;
          en_q   <= req_enable;
          kind_q <= req_path[0] ? K_EAR : req_path[3] ? K_LO : K_HP;
          mode_q <= req_mode;
          path_q <= req_path;
          idx    <= '0;
        end
      end
      if (step == S_WAIT && us_tick) wcnt <= adv ? '0 : wcnt + 1'b1;
      if (adv) begin
        idx <= idx + 4'd1;
        case (step)
          S_CLSH: if (uses_clsh) begin
            path_clsh_en[psel] <= en_q;
            if (en_q) begin
              if (users == '0) clsh_clk_en <= 1'b1;
              if (users != '1) users <= users + 1'b1;
              if (kind_q == K_HP) k1_coef <= K1_LOAD;
            end else if (users != '0) begin
              users <= users - 1'b1;
              if (users == USER_W'(1)) clsh_clk_en <= 1'b0;
            end
          end
          S_REG:  reg_ab    <= en_q && (mode_q == M_AB);
          S_NLVL: vneg_hifi <= en_q && (mode_q == M_HIFI);
          S_PLVL: vpos_hifi <= en_q && (mode_q == M_HIFI);
          S_BIAS: bias_load <= 1'b1;
          S_HPH: begin
            hph_pwr    <= !en_q ? L_NORM : (mode_q == M_HIFI) ? L_HQ : (mode_q == M_LP) ? L_LP : L_NORM;
            ipeak_30ma <= en_q && (mode_q == M_LP);
          end
          S_GAIN: gain_sel <= (mode_q == M_HIFI) ? L_HQ : (mode_q == M_LP) ? L_LP : L_NORM;
          default: ;
        endcase
        if (step_nx == S_END) begin
          run       <= 1'b0;
          cur_state <= en_q ? (cur_state | path_q) : (cur_state & ~path_q);
          cur_mode  <= mode_q;
        end
      end
    end
  end

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_req && !rail_ack) |=> (rail_req && $stable(rail_pos) && $stable(rail_on)));

  a_r3_err_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !busy);

  a_r12_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(cur_state) && $stable(cur_mode))));

  a_r10_wait_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (step == S_WAIT && !us_tick) |=> (step == S_WAIT));

  a_r8_clk_users: assert property (@(posedge clk) disable iff (!rst_n)
    clsh_clk_en == (users != '0));

endmodule

// File: tb/hp_supply_seq_tb.sv
module hp_supply_seq_tb;
  localparam int BIAS_US  = 100;
  localparam int TICK_DIV = 3;
  localparam int RAIL_LAT = 2;
  localparam int T_CLSH = 1, T_REG = 2, T_NLVL = 3, T_NRAIL = 4, T_BIAS = 5, T_WAIT = 6,
                 T_PLVL = 7, T_PRAIL = 8, T_HPH = 9, T_GAIN = 10;

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, req_valid = 1'b0, req_enable = 1'b0, rail_ack = 1'b0;
  logic [3:0] req_path = '0;
  logic [2:0] req_mode = '0;
  logic busy, req_err, clsh_clk_en, reg_ab, vneg_hifi, vpos_hifi, bias_load, ipeak_30ma;
  logic rail_req, rail_pos, rail_on;
  logic [3:0] cur_state;
  logic [2:0] cur_mode, path_clsh_en;
  logic [11:0] k1_coef;
  logic [1:0] hph_pwr, gain_sel;

  always #4 clk = ~clk;

  hp_supply_seq #(.BIAS_US(BIAS_US)) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .req_valid(req_valid), .req_enable(req_enable),
    .req_path(req_path), .req_mode(req_mode), .rail_ack(rail_ack), .busy(busy), .req_err(req_err),
    .cur_state(cur_state), .cur_mode(cur_mode), .clsh_clk_en(clsh_clk_en), .path_clsh_en(path_clsh_en),
    .k1_coef(k1_coef), .reg_ab(reg_ab), .vneg_hifi(vneg_hifi), .vpos_hifi(vpos_hifi),
    .bias_load(bias_load), .hph_pwr(hph_pwr), .ipeak_30ma(ipeak_30ma), .gain_sel(gain_sel),
    .rail_req(rail_req), .rail_pos(rail_pos), .rail_on(rail_on));

  int vecs = 0, miss = 0, cyc = 0, rail_cnt = 0, tick_div = 0, tick_cnt = 0, t0 = 0;
  bit bias_seen = 0, wait_chk = 0;
  string ctx = "R1 reset";

  int q[$];
  bit m_run, m_en, m_err, m_clk, m_ab, m_vn, m_vp, m_bias, m_ip, m_adv;
  int m_kind, m_mode, m_path, m_wcnt, m_users, m_state, m_cmode, m_hph, m_gain, m_k1, m_pen, m_st, m_new;

  task automatic cmp(string tag, int act, int exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s | %s: actual %0h expected %0h", ctx, tag, act, exp);
    end
  endtask

  function automatic bit legal(int path, int mode);
    if (path[0]) return mode == 0;
    if (path[3]) return mode == 3;
    if (path[1] || path[2]) return mode >= 1 && mode <= 5;
    return 1'b1;
  endfunction

  task automatic build(bit en, int kind);
    q.delete();
    if (en) begin
      if (kind == 0) q = '{T_CLSH, T_PLVL, T_NLVL, T_NRAIL, T_BIAS, T_WAIT, T_PRAIL};
      else if (kind == 1) q = '{T_CLSH, T_REG, T_NLVL, T_NRAIL, T_BIAS, T_WAIT, T_PLVL, T_PRAIL, T_HPH, T_GAIN};
      else q = '{T_REG, T_PLVL, T_NLVL, T_NRAIL, T_BIAS, T_WAIT, T_PRAIL};
    end else begin
      if (kind == 0) q = '{T_CLSH, T_PRAIL, T_NRAIL, T_NLVL, T_PLVL};
      else if (kind == 1) q = '{T_HPH, T_CLSH, T_PRAIL, T_NRAIL, T_NLVL, T_PLVL, T_REG};
      else q = '{T_PRAIL, T_NRAIL, T_NLVL, T_PLVL, T_REG};
    end
  endtask

  task automatic apply(int st);
    int b;
    b = m_path[0] ? 0 : m_path[1] ? 1 : 2;
    case (st)
      T_CLSH: if (m_mode != 3) begin
        if (m_en) begin
          if (m_users == 0) m_clk = 1;
          m_users++;
          m_pen = m_pen | (1 << b);
          if (m_kind == 1) m_k1 = 'h0C0;
        end else begin
          m_pen = m_pen & ~(1 << b);
          if (m_users > 0) begin m_users--; if (m_users == 0) m_clk = 0; end
        end
      end
      T_REG:  m_ab = m_en && m_mode == 3;
      T_NLVL: m_vn = m_en && m_mode == 1;
      T_PLVL: m_vp = m_en && m_mode == 1;
      T_BIAS: m_bias = 1;
      T_HPH: begin
        m_hph = !m_en ? 0 : (m_mode == 1) ? 2 : (m_mode == 2) ? 1 : 0;
        m_ip  = m_en && m_mode == 2;
      end
      T_GAIN: m_gain = (m_mode == 1) ? 2 : (m_mode == 2) ? 1 : 0;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_run = 0; m_en = 0; m_err = 0; m_clk = 0; m_ab = 0; m_vn = 0; m_vp = 0; m_bias = 0; m_ip = 0;
      m_kind = 0; m_mode = 0; m_path = 0; m_wcnt = 0; m_users = 0; m_state = 0; m_cmode = 0;
      m_hph = 0; m_gain = 0; m_k1 = 0; m_pen = 0;
    end else begin
      m_err = 0; m_bias = 0;
      if (m_run) begin
        m_st = q[0];
        m_adv = 0;
        if (m_st == T_NRAIL || m_st == T_PRAIL) m_adv = rail_ack;
        else if (m_st == T_WAIT) begin
          if (us_tick) begin
            if (m_wcnt == BIAS_US - 1) begin m_adv = 1; m_wcnt = 0; end
            else m_wcnt++;
          end
        end else m_adv = 1;
        if (m_adv) begin
          apply(m_st);
          void'(q.pop_front());
          if (q.size() == 0) begin
            m_run = 0;
            m_state = m_en ? (m_state | m_path) : (m_state & ~m_path);
            m_cmode = m_mode;
          end
        end
      end else if (req_valid) begin
        m_new = req_enable ? (m_state | req_path) : (m_state & ~int'(req_path));
        if (m_new != m_state) begin
          if ($countones(req_path) > 1 || !legal(req_path, req_mode)) m_err = 1;
          else begin
            m_run = 1; m_en = req_enable; m_mode = req_mode; m_path = req_path;
            m_kind = req_path[0] ? 0 : req_path[3] ? 2 : 1;
            build(m_en, m_kind);
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      cmp("R12 busy", busy, m_run);
      cmp("R3/R4 req_err", req_err, m_err);
      cmp("R2 cur_state", cur_state, m_state);
      cmp("R12 cur_mode", cur_mode, m_cmode);
      cmp("R8 clsh_clk_en", clsh_clk_en, m_clk);
      cmp("R8 path_clsh_en", path_clsh_en, m_pen);
      cmp("R9 k1_coef", k1_coef, m_k1);
      cmp("R9 reg_ab", reg_ab, m_ab);
      cmp("R9 vneg_hifi", vneg_hifi, m_vn);
      cmp("R9 vpos_hifi", vpos_hifi, m_vp);
      cmp("R10 bias_load", bias_load, m_bias);
      cmp("R9 hph_pwr", hph_pwr, m_hph);
      cmp("R9 ipeak_30ma", ipeak_30ma, m_ip);
      cmp("R9 gain_sel", gain_sel, m_gain);
      cmp("R11 rail_req", rail_req, m_run && (q[0] == T_NRAIL || q[0] == T_PRAIL));
      cmp("R11 rail_pos", rail_pos, m_run && q[0] == T_PRAIL);
      cmp("R11 rail_on", rail_on, m_run && m_en && (q[0] == T_NRAIL || q[0] == T_PRAIL));
    end
    if (us_tick) tick_cnt++;
    if (bias_load) begin t0 = tick_cnt; bias_seen = 1; end
    else if (bias_seen && rail_req && rail_pos) begin
      bias_seen = 0;
      if (wait_chk) cmp("R10 ticks from bias load to next step", tick_cnt - t0, BIAS_US);
    end
    if (rail_ack) begin rail_ack <= 1'b0; rail_cnt = 0; end
    else if (rail_req) begin rail_cnt++; if (rail_cnt == RAIL_LAT) rail_ack <= 1'b1; end
    else rail_cnt = 0;
    tick_div = (tick_div == TICK_DIV - 1) ? 0 : tick_div + 1;
    us_tick <= (tick_div == 0);
    if (cyc > 150000) begin
      miss++;
      $display("FAIL watchdog expired in %s", ctx);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  task automatic send(bit en, int path, int mode);
    @(negedge clk);
    req_valid = 1'b1; req_enable = en; req_path = path[3:0]; req_mode = mode[2:0];
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ctx = "R1 reset";
    cmp("R1 busy", busy, 0); cmp("R1 cur_state", cur_state, 0); cmp("R1 clk", clsh_clk_en, 0);
    cmp("R1 gain_sel", gain_sel, 0); cmp("R1 k1", k1_coef, 0); cmp("R1 rail_req", rail_req, 0);

    ctx = "R5 left headphone enable HiFi";
    send(1, 4'b0010, 1); wait_idle();
    cmp("R5 cur_state", cur_state, 4'b0010); cmp("R9 k1", k1_coef, 'h0C0);
    cmp("R9 gain HQ", gain_sel, 2); cmp("R9 hph HiFi", hph_pwr, 2); cmp("R8 clk on", clsh_clk_en, 1);

    ctx = "R2 ignored requests";
    send(1, 4'b0010, 1); cmp("R2 busy", busy, 0); cmp("R2 err", req_err, 0);
    send(0, 4'b0001, 0); cmp("R2 busy", busy, 0);
    send(1, 4'b0000, 2); cmp("R2 busy", busy, 0);
    repeat (2) @(negedge clk);
    cmp("R2 state", cur_state, 4'b0010);

    ctx = "R3 multi-bit path";
    send(1, 4'b0110, 1); cmp("R3 err", req_err, 1); cmp("R3 busy", busy, 0);
    @(negedge clk); cmp("R3 err one cycle", req_err, 0); cmp("R3 state", cur_state, 4'b0010);

    ctx = "R4 illegal modes";
    send(1, 4'b0001, 1); cmp("R4 ear HiFi err", req_err, 1);
    send(1, 4'b1000, 0); cmp("R4 line-out normal err", req_err, 1);
    send(1, 4'b0100, 0); cmp("R4 headphone normal err", req_err, 1);
    send(1, 4'b0100, 6); cmp("R4 headphone code 6 err", req_err, 1);
    @(negedge clk); cmp("R4 state", cur_state, 4'b0010);

    ctx = "R5 right headphone enable low power";
    send(1, 4'b0100, 2);
    repeat (5) @(negedge clk);
    ctx = "R12 request while busy";
    send(1, 4'b1000, 3); cmp("R12 no err", req_err, 0);
    wait_idle();
    cmp("R12 state", cur_state, 4'b0110); cmp("R12 mode", cur_mode, 2);
    cmp("R9 gain LP", gain_sel, 1); cmp("R9 ipeak", ipeak_30ma, 1); cmp("R9 hph LP", hph_pwr, 1);

    ctx = "R7 left headphone disable";
    send(0, 4'b0010, 1); wait_idle();
    cmp("R8 clk held", clsh_clk_en, 1); cmp("R8 path en", path_clsh_en, 3'b100);
    ctx = "R7 right headphone disable";
    send(0, 4'b0100, 2); wait_idle();
    cmp("R8 clk off", clsh_clk_en, 0); cmp("R7 state", cur_state, 0); cmp("R7 gain kept", gain_sel, 1);

    ctx = "R6 earpiece enable"; wait_chk = 1;
    send(1, 4'b0001, 0); wait_idle(); wait_chk = 0;
    cmp("R8 clk ear", clsh_clk_en, 1); cmp("R6 state", cur_state, 4'b0001);
    ctx = "R7 earpiece disable";
    send(0, 4'b0001, 0); wait_idle(); cmp("R8 clk off", clsh_clk_en, 0);

    ctx = "R6 line-out enable"; wait_chk = 1;
    send(1, 4'b1000, 3); wait_idle(); wait_chk = 0;
    cmp("R9 reg_ab", reg_ab, 1); cmp("R8 no clk", clsh_clk_en, 0);
    ctx = "R7 line-out disable";
    send(0, 4'b1000, 3); wait_idle(); cmp("R7 reg_ab", reg_ab, 0);

    ctx = "R5 left headphone class-AB";
    send(1, 4'b0010, 3); wait_idle();
    cmp("R5 no clk", clsh_clk_en, 0); cmp("R5 path en", path_clsh_en, 0); cmp("R9 gain bypass", gain_sel, 0);
    ctx = "R7 left headphone class-AB disable";
    send(0, 4'b0010, 3); wait_idle();

    ctx = "R9 right headphone low HiFi";
    send(1, 4'b0100, 4); wait_idle();
    cmp("R9 vpos", vpos_hifi, 0); cmp("R9 hph", hph_pwr, 0); cmp("R8 clk", clsh_clk_en, 1);
    ctx = "R7 right headphone low HiFi disable";
    send(0, 4'b0100, 4); wait_idle();
    cmp("R7 final state", cur_state, 0); cmp("R8 final clk", clsh_clk_en, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule